// File: doc/BRIEF.md
# Feedback-Throttled Stream Prefetcher

This block watches the demand traffic of a cache and picks out ascending streams from its miss addresses. Each tracked stream has a start block. The block issues prefetches for the blocks above that start, up to a distance ahead of it. When a demand lands inside the window of a stream, the start moves up by a degree, and that frees further prefetches. Distance and degree are not fixed. Both come from one of five aggressiveness levels, and the level is reconsidered at the end of every measurement interval.

During an interval the block counts five things: the prefetches it has issued, demands that touched a prefetched block (useful), demands that found their prefetch still in flight (late), demand misses, and demand misses that point at blocks recently pushed out by prefetch fills (pollution). A Bloom filter of those evicted blocks detects the pollution, and it is emptied at every interval boundary. The surrounding cache reports its events on plain valid-qualified inputs. In return it receives the prefetch requests, the current level and a flag that asks it to insert prefetched blocks at a low replacement position rather than MRU.

Top module: `adaptive_stream_prefetcher`

## Requirements
- R1: After reset the level is 2, the distance is 16, the degree is 2, the low-insertion flag is 0 and no prefetch is requested.
- R2: A demand miss that falls in no stream window claims a stream slot (slots are taken in rotating order). That stream's start is the miss address, and its prefetches begin at start+1 and go up by one block for each accepted request (pf_valid and pf_ready high at a clock edge).
- R3: A stream requests no block beyond start+distance. When several streams have pending work, the lowest slot index is served first.
- R4: A demand whose address lies in [start, start+distance] of a stream moves that start up by the degree. If the next block to prefetch is then not above the new start, prefetching resumes at new start+1.
- R5: Levels 0 to 4 map to (distance, degree) = (4,1), (8,1), (16,2), (32,4), (64,4).
- R6: An interval closes on the edge that accepts its INTERVAL_EVICTS-th eviction. The level and the low-insertion flag change only there, and all interval counts restart from zero afterwards.
- R7: At a close, if useful×4 ≥ issued×3, late×100 > useful, issued > 0 and R8 does not apply, the level rises by one.
- R8: At a close, the level falls by one if issued > 0 and useful×5 < issued×2, or if pollution×20 > demand misses. This takes precedence over R7. With no prefetch issued, the accuracy tests are skipped.
- R9: The level never leaves the range 0..4. A step that would leave the range leaves the level unchanged.
- R10: An eviction flagged as caused by a prefetch fill enters its address into the filter (two XOR-fold hash bits). A demand miss whose hash bits are both set counts as pollution. The filter is cleared at every interval close.
- R11: The low-insertion flag is set at a close where pollution×20 > demand misses, and is cleared at a close where that does not hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dem_valid | input | 1 | Demand access this cycle |
| dem_addr | input | ADDR_W | Block address of the demand |
| dem_miss | input | 1 | Demand missed the cache |
| dem_pf_used | input | 1 | Demand touched a block whose prefetched bit was set |
| dem_pf_late | input | 1 | Demand matched a prefetch still outstanding in the MSHR |
| evict_valid | input | 1 | A block left the cache this cycle |
| evict_addr | input | ADDR_W | Block address of the evicted block |
| evict_pf_fill | input | 1 | The eviction was caused by a prefetch fill |
| pf_ready | input | 1 | Memory side accepts a prefetch request |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | ADDR_W | Block address to prefetch |
| aggr_level | output | 3 | Current aggressiveness level |
| pf_distance | output | 8 | Current prefetch distance in blocks |
| pf_degree | output | 4 | Current start advance in blocks |
| insert_low | output | 1 | Insert prefetched blocks at low replacement position |

## Verification
The bench lowers the level from above, changing distance mid-stream. A stream whose window shrank would keep issuing past the new limit if the limit were latched at allocation instead of read live. It drives an interval with no prefetches issued, where a design that divided by zero or tested accuracy anyway would drop a level it should hold. Pollution is injected through a prefetch-fill eviction followed by a miss to the same block. The same miss in the next interval must not count, so a filter that is never cleared would keep lowering the level and keep low insertion on. The bench pushes the level to the floor twice to catch a wrap from 0 to 7. It also tracks a start advance that overtakes a stalled prefetch pointer, which would otherwise refetch blocks behind the start.

// File: rtl/asp_pkg.sv
package asp_pkg;
   localparam int LEVELS = 5;
   localparam int LVL_W  = 3;
   localparam int DIST_W = 8;
   localparam int DEG_W  = 4;
   localparam logic [LVL_W-1:0] LVL_START = 3'd2;
   localparam logic [LVL_W-1:0] LVL_TOP   = 3'(LEVELS - 1);

   // distance doubles per level, starting at 4 blocks
   function automatic logic [DIST_W-1:0] lvl_to_distance(input logic [LVL_W-1:0] lvl);
      return DIST_W'(4) << lvl;
   endfunction

   function automatic logic [DEG_W-1:0] lvl_to_degree(input logic [LVL_W-1:0] lvl);
      case (lvl)
         3'd0, 3'd1: return DEG_W'(1);
         3'd2:       return DEG_W'(2);
         default:    return DEG_W'(4);
      endcase
   endfunction
endpackage

// File: rtl/asp_stream_table.sv
module asp_stream_table #(
   parameter int ADDR_W      = 32,
   parameter int NUM_STREAMS = 4,
   parameter int DIST_W      = 8,
   parameter int DEG_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dem_valid,
   input  logic [ADDR_W-1:0] dem_addr,
   input  logic              dem_miss,
   input  logic [DIST_W-1:0] distance,
   input  logic [DEG_W-1:0]  degree,
   input  logic              pf_ready,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              pf_fire
);
   localparam int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

   logic [NUM_STREAMS-1:0]        hit_vec;
   logic [NUM_STREAMS-1:0]        pend_vec;
   logic [NUM_STREAMS*ADDR_W-1:0] next_flat;
   logic [IDX_W-1:0]              alloc_ptr;
   logic [IDX_W-1:0]              sel_idx;
   logic                          sel_any;
   logic                          do_alloc;

   assign do_alloc = dem_valid & dem_miss & ~|hit_vec;
   assign pf_fire  = sel_any & pf_ready;
   assign pf_valid = sel_any;
   assign pf_addr  = next_flat[sel_idx*ADDR_W +: ADDR_W];

   // lowest pending slot wins
   always_comb begin
      sel_any = 1'b0;
      sel_idx = '0;
      for (int k = NUM_STREAMS - 1; k >= 0; k--) begin
         if (pend_vec[k]) begin
            sel_any = 1'b1;
            sel_idx = IDX_W'(k);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         alloc_ptr <= '0;
      else if (do_alloc)
         alloc_ptr <= (alloc_ptr == IDX_W'(NUM_STREAMS - 1)) ? '0 : alloc_ptr + 1'b1;
   end

   for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_slot
      logic              vld_q;
      logic [ADDR_W-1:0] start_q;
      logic [ADDR_W-1:0] next_q;
      logic [ADDR_W-1:0] limit;
      logic [ADDR_W-1:0] moved_start;
      logic [ADDR_W-1:0] stepped;

      assign limit       = start_q + ADDR_W'(distance);
      assign moved_start = start_q + ADDR_W'(degree);
      assign hit_vec[i]  = vld_q & dem_valid & (dem_addr >= start_q) & (dem_addr <= limit);
      assign pend_vec[i] = vld_q & (next_q <= limit);
      assign next_flat[i*ADDR_W +: ADDR_W] = next_q;
      assign stepped     = (pf_fire && sel_idx == IDX_W'(i)) ? next_q + 1'b1 : next_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q   <= 1'b0;
            start_q <= '0;
            next_q  <= '0;
         end else if (do_alloc && alloc_ptr == IDX_W'(i)) begin
            vld_q   <= 1'b1;
            start_q <= dem_addr;
            next_q  <= dem_addr + 1'b1;
         end else if (hit_vec[i]) begin
            start_q <= moved_start;
            next_q  <= (stepped <= moved_start) ? moved_start + 1'b1 : stepped;
         end else begin
            next_q  <= stepped;
         end
      end
   end
endmodule

// File: rtl/asp_bloom.sv
module asp_bloom #(
   parameter int ADDR_W = 32,
   parameter int BITS   = 4096,
   parameter int HASHES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_hit
);
   localparam int HW     = $clog2(BITS);
   localparam int CHUNKS = (ADDR_W + HW - 1) / HW;
   localparam int PAD    = CHUNKS * HW;

   function automatic logic [HW-1:0] fold(input logic [ADDR_W-1:0] a);
      logic [PAD-1:0] ext;
      logic [HW-1:0]  r;
      ext = PAD'(a);
      r   = '0;
      for (int c = 0; c < CHUNKS; c++) r ^= ext[c*HW +: HW];
      return r;
   endfunction

   function automatic logic [ADDR_W-1:0] mirror(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] r;
      for (int b = 0; b < ADDR_W; b++) r[b] = a[ADDR_W-1-b];
      return r;
   endfunction

   logic [BITS-1:0] filt_q;
   logic [HW-1:0]   ins_h1, ins_h2, q_h1, q_h2;

   assign ins_h1 = fold(ins_addr);
   assign q_h1   = fold(q_addr);

   if (HASHES == 2) begin : g_two
      assign ins_h2 = fold(mirror(ins_addr));
      assign q_h2   = fold(mirror(q_addr));
   end else begin : g_one
      assign ins_h2 = ins_h1;
      assign q_h2   = q_h1;
   end

   assign q_hit = filt_q[q_h1] & filt_q[q_h2];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         filt_q <= '0;
      end else if (ins_valid) begin
         filt_q[ins_h1] <= 1'b1;
         filt_q[ins_h2] <= 1'b1;
      end
   end
endmodule

// File: rtl/asp_throttle.sv
module asp_throttle
   import asp_pkg::*;
#(
   parameter int INTERVAL = 8192,
   parameter int CNT_W    = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issued_ev,
   input  logic             used_ev,
   input  logic             late_ev,
   input  logic             miss_ev,
   input  logic             pollute_ev,
   input  logic             evict_ev,
   output logic             interval_end,
   output logic [LVL_W-1:0] level,
   output logic             insert_low
);
   localparam int EV_W = $clog2(INTERVAL);
   localparam int MW   = CNT_W + 7;

   function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic inc);
      return (inc && v != '1) ? v + 1'b1 : v;
   endfunction

   logic [CNT_W-1:0] iss_q, use_q, late_q, miss_q, pol_q;
   logic [CNT_W-1:0] iss_n, use_n, late_n, miss_n, pol_n;
   logic [EV_W-1:0]  ev_q;
   logic acc_hi, acc_lo, late_hi, pol_hi, go_up, go_down;

   assign iss_n  = bump(iss_q, issued_ev);
   assign use_n  = bump(use_q, used_ev);
   assign late_n = bump(late_q, late_ev);
   assign miss_n = bump(miss_q, miss_ev);
   assign pol_n  = bump(pol_q, pollute_ev);

   assign interval_end = evict_ev && (ev_q == EV_W'(INTERVAL - 1));

   assign acc_hi  = (iss_n != '0) && (MW'(use_n) * MW'(4) >= MW'(iss_n) * MW'(3));
   assign acc_lo  = (iss_n != '0) && (MW'(use_n) * MW'(5) <  MW'(iss_n) * MW'(2));
   assign late_hi = MW'(late_n) * MW'(100) > MW'(use_n);
   assign pol_hi  = MW'(pol_n) * MW'(20) > MW'(miss_n);
   assign go_down = acc_lo | pol_hi;
   assign go_up   = acc_hi & late_hi & ~go_down;

   always_ff @(posedge clk) begin
      if (!rst_n || interval_end) begin
         iss_q  <= '0;
         use_q  <= '0;
         late_q <= '0;
         miss_q <= '0;
         pol_q  <= '0;
      end else begin
         iss_q  <= iss_n;
         use_q  <= use_n;
         late_q <= late_n;
         miss_q <= miss_n;
         pol_q  <= pol_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ev_q <= '0;
      else if (interval_end)
         ev_q <= '0;
      else if (evict_ev)
         ev_q <= ev_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level      <= LVL_START;
         insert_low <= 1'b0;
      end else if (interval_end) begin
         insert_low <= pol_hi;
         if (go_down && level != '0)
            level <= level - 1'b1;
         else if (go_up && level != LVL_TOP)
            level <= level + 1'b1;
      end
   end
endmodule

// File: rtl/adaptive_stream_prefetcher.sv
module adaptive_stream_prefetcher
   import asp_pkg::*;
#(
   parameter int ADDR_W          = 32,
   parameter int NUM_STREAMS     = 4,
   parameter int INTERVAL_EVICTS = 8192,
   parameter int BLOOM_BITS      = 4096,
   parameter int BLOOM_HASHES    = 2,
   parameter int CNT_W           = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dem_valid,
   input  logic [ADDR_W-1:0] dem_addr,
   input  logic              dem_miss,
   input  logic              dem_pf_used,
   input  logic              dem_pf_late,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              evict_pf_fill,
   input  logic              pf_ready,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [2:0]        aggr_level,
   output logic [7:0]        pf_distance,
   output logic [3:0]        pf_degree,
   output logic              insert_low
);
   if (NUM_STREAMS < 1) begin : g_bad_streams
      $error("NUM_STREAMS must be at least 1");
   end
   if (INTERVAL_EVICTS < 2) begin : g_bad_interval
      $error("INTERVAL_EVICTS must be at least 2");
   end
   if (BLOOM_BITS < 2 || (BLOOM_BITS & (BLOOM_BITS - 1)) != 0) begin : g_bad_bloom
      $error("BLOOM_BITS must be a power of two");
   end
   if (BLOOM_HASHES < 1 || BLOOM_HASHES > 2) begin : g_bad_hashes
      $error("BLOOM_HASHES must be 1 or 2");
   end
   if (CNT_W < 8) begin : g_bad_cnt
      $error("CNT_W too narrow");
   end

   logic             interval_end;
   logic             pf_fire;
   logic             pollute_hit;
   logic [LVL_W-1:0] level;

   assign aggr_level  = level;
   assign pf_distance = lvl_to_distance(level);
   assign pf_degree   = lvl_to_degree(level);

   asp_stream_table #(
      .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS), .DIST_W(DIST_W), .DEG_W(DEG_W)
   ) u_streams (
      .clk(clk), .rst_n(rst_n),
      .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_miss(dem_miss),
      .distance(pf_distance), .degree(pf_degree),
      .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_fire(pf_fire)
   );

   asp_bloom #(
      .ADDR_W(ADDR_W), .BITS(BLOOM_BITS), .HASHES(BLOOM_HASHES)
   ) u_bloom (
      .clk(clk), .rst_n(rst_n), .clear(interval_end),
      .ins_valid(evict_valid & evict_pf_fill), .ins_addr(evict_addr),
      .q_addr(dem_addr), .q_hit(pollute_hit)
   );

   asp_throttle #(
      .INTERVAL(INTERVAL_EVICTS), .CNT_W(CNT_W)
   ) u_throttle (
      .clk(clk), .rst_n(rst_n),
      .issued_ev(pf_fire),
      .used_ev(dem_valid & dem_pf_used),
      .late_ev(dem_valid & dem_pf_late),
      .miss_ev(dem_valid & dem_miss),
      .pollute_ev(dem_valid & dem_miss & pollute_hit),
      .evict_ev(evict_valid),
      .interval_end(interval_end),
      .level(level),
      .insert_low(insert_low)
   );
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] aggr_level,
   input logic       insert_low,
   input logic       interval_end
);
   assert_level_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      aggr_level <= 3'd4);

   assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !interval_end |=> $stable(aggr_level));

   assert_level_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      interval_end |=> (aggr_level == $past(aggr_level)) ||
                       (aggr_level == $past(aggr_level) + 3'd1) ||
                       (aggr_level + 3'd1 == $past(aggr_level)));

   assert_insert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !interval_end |=> $stable(insert_low));
endmodule

bind adaptive_stream_prefetcher asp_checker u_chk (
   .clk(clk), .rst_n(rst_n), .aggr_level(aggr_level),
   .insert_low(insert_low), .interval_end(interval_end)
);

// File: tb/adaptive_stream_prefetcher_tb.sv
`timescale 1ns/1ps
module adaptive_stream_prefetcher_tb;
   localparam int AW = 32;
   localparam int IV = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dem_valid = 1'b0, dem_miss = 1'b0, dem_pf_used = 1'b0, dem_pf_late = 1'b0;
   logic [AW-1:0] dem_addr = '0, evict_addr = '0, pf_addr;
   logic          evict_valid = 1'b0, evict_pf_fill = 1'b0, pf_ready = 1'b0;
   logic          pf_valid, insert_low;
   logic [2:0]    aggr_level;
   logic [7:0]    pf_distance;
   logic [3:0]    pf_degree;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adaptive_stream_prefetcher #(
      .ADDR_W(AW), .NUM_STREAMS(4), .INTERVAL_EVICTS(IV), .BLOOM_BITS(256), .BLOOM_HASHES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_miss(dem_miss),
      .dem_pf_used(dem_pf_used), .dem_pf_late(dem_pf_late),
      .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_pf_fill(evict_pf_fill),
      .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
      .aggr_level(aggr_level), .pf_distance(pf_distance), .pf_degree(pf_degree),
      .insert_low(insert_low)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   // one demand access, applied for one clock edge
   task automatic demand(input longint a, input bit miss, input bit used, input bit late);
      dem_valid = 1'b1; dem_addr = AW'(a); dem_miss = miss; dem_pf_used = used; dem_pf_late = late;
      @(negedge clk);
      dem_valid = 1'b0; dem_miss = 1'b0; dem_pf_used = 1'b0; dem_pf_late = 1'b0;
   endtask

   task automatic evicts(input int n, input longint a, input bit by_pf);
      for (int i = 0; i < n; i++) begin
         evict_valid = 1'b1; evict_addr = AW'(a); evict_pf_fill = by_pf;
         @(negedge clk);
      end
      evict_valid = 1'b0; evict_pf_fill = 1'b0;
   endtask

   // accept prefetches for a number of cycles, checking they ascend by one
   task automatic collect(input string req, input int cycles,
                          output int cnt, output longint first, output longint last);
      cnt = 0; first = -1; last = -1;
      pf_ready = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         if (pf_valid) begin
            if (cnt > 0) check(req, longint'(pf_addr), last + 1);
            if (cnt == 0) first = longint'(pf_addr);
            last = longint'(pf_addr);
            cnt++;
         end
         @(negedge clk);
      end
      pf_ready = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 level", aggr_level, 2);
      check("R1 distance", pf_distance, 16);
      check("R1 degree", pf_degree, 2);
      check("R1 insert_low", insert_low, 0);
      check("R1 pf_valid", pf_valid, 0);
   endtask

   task automatic t_stream();
      int cnt; longint f, l;
      demand(1000, 1, 0, 0);
      collect("R2 ascending", 30, cnt, f, l);
      check("R2 first", f, 1001);
      check("R3 count at distance 16", cnt, 16);
      check("R3 last", l, 1016);
      demand(1005, 0, 0, 0);          // hit: start 1000 -> 1002
      collect("R4 ascending", 10, cnt, f, l);
      check("R4 count after advance", cnt, 2);
      check("R4 first after advance", f, 1017);
   endtask

   task automatic t_raise();
      // interval: 18 issued so far; 18 useful, 1 late
      for (int i = 0; i < 18; i++) demand(90000 + i, 0, 1, i == 0);
      evicts(IV, 5, 0);
      check("R7 level up", aggr_level, 3);
      check("R5 distance level 3", pf_distance, 32);
      check("R5 degree level 3", pf_degree, 4);
   endtask

   task automatic t_lower_accuracy();
      int cnt; longint f, l;
      collect("R3 ascending", 40, cnt, f, l);
      check("R3 count with distance 32", cnt, 16);
      check("R3 last with distance 32", l, 1034);
      evicts(IV - 1, 6, 0);
      check("R6 no change before close", aggr_level, 3);
      evicts(1, 6, 0);
      check("R8 accuracy down", aggr_level, 2);
   endtask

   task automatic t_pollution();
      evicts(1, 7000, 1);
      demand(7000, 1, 0, 0);
      evicts(IV - 1, 8, 0);
      check("R10 pollution lowers level", aggr_level, 1);
      check("R11 insert_low set", insert_low, 1);
      check("R5 distance level 1", pf_distance, 8);
   endtask

   task automatic t_cleared();
      demand(7000, 1, 0, 0);          // hit stream 7000, start -> 7001
      evicts(IV, 9, 0);
      check("R10 filter cleared, level held", aggr_level, 1);
      check("R11 insert_low cleared", insert_low, 0);
   endtask

   task automatic t_floor();
      int cnt; longint f, l;
      collect("R4 resume ascending", 20, cnt, f, l);
      check("R4 resume after overtaken pointer", f, 7002);
      check("R3 count with distance 8", cnt, 8);
      evicts(IV, 10, 0);
      check("R8 down to 0", aggr_level, 0);
      demand(20000, 1, 0, 0);
      collect("R2 ascending level 0", 10, cnt, f, l);
      check("R5 count with distance 4", cnt, 4);
      evicts(IV, 11, 0);
      check("R9 clamp at 0", aggr_level, 0);
      check("R5 distance level 0", pf_distance, 4);
      check("R5 degree level 0", pf_degree, 1);
   endtask

   task automatic t_rise_from_floor();
      int cnt; longint f, l;
      demand(30000, 1, 0, 0);
      collect("R2 ascending new slot", 10, cnt, f, l);
      check("R2 first of new stream", f, 30001);
      check("R3 count new stream", cnt, 4);
      for (int i = 0; i < 4; i++) demand(95000 + i, 0, 1, i == 2);
      evicts(IV, 12, 0);
      check("R7 up from 0", aggr_level, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stream();
      t_raise();
      t_lower_accuracy();
      t_pollution();
      t_cleared();
      t_floor();
      t_rise_from_floor();
      finish_run();
   end
endmodule